// File: doc/BRIEF.md
# RTC Alarm and Interrupt Flag Unit

This block is the alarm and interrupt section of a PC-style real-time clock. A timekeeping counter outside the block supplies the current seconds, minutes, hours, day of month and month. It also supplies a one-cycle pulse on every one-second update. The block holds the alarm registers, a control register and a rate register. It latches three event flags: periodic, alarm and update. From those flags and their enables it forms a summary interrupt bit and an active-low interrupt line.

Software uses a small register port. Writes take effect at the clock edge, and read data appears one cycle after the read strobe. Reading the flag register returns the flags and clears them. A periodic divider runs from a 32.768 kHz reference enable pulse. Its division ratio is chosen by a 4-bit rate code.

Register addresses (`addr`):

| Address | Register | Notes |
| --- | --- | --- |
| 0 | seconds alarm | |
| 1 | minutes alarm | |
| 2 | hours alarm | |
| 3 | day alarm | |
| 4 | month alarm | |
| 5 | rate | bits 3:0 only |
| 6 | control | |
| 7 | flags | read-only |

Control bits: bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 2 binary mode (0 selects BCD), bit 1 24-hour mode. Flag register: bit 7 summary, bit 6 periodic flag, bit 5 alarm flag, bit 4 update flag. Bits 3:0 of the flag register read as 0.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, the alarm registers, the rate register and the flags read 0. The control register reads 0x02 (24-hour mode, BCD, all enables off). `irq_n` is high.
- R2: Alarm and control registers read back exactly the byte written. The rate register reads back only bits 3:0 of the written byte, with bits 7:4 as zero. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: The update flag (flag bit 4) sets on every `upd_tick` pulse, whether or not its enable is set.
- R4: On an `upd_tick`, the alarm flag (bit 5) sets when every non-wildcard alarm field equals the current time. A field whose bits 7:6 are both 1 is a wildcard. A day alarm whose low six bits are zero is unused. Only the low six bits of the day alarm are compared.
- R5: Control bit 2 selects the validity rule. In BCD mode (bit 2 = 0), a field must have both nibbles at most 9 and stay within 0x59 (seconds, minutes), 0x31 (day) or 0x12 (month). In binary mode (bit 2 = 1), the limits are 59, 31 and 12. A non-wildcard field that breaks its rule never matches, even when it equals the current value.
- R6: Control bit 1 selects the hour rule. In 24-hour mode the limit is 0x23 (BCD) or 23 (binary). In 12-hour mode, bit 7 is the PM marker, and bits 6:0 must lie between 1 and 12 (BCD 0x01 to 0x12).
- R7: A write to the rate register restarts the divider. Rate code r from 3 to 15 sets the periodic flag (bit 6) on every 2^(r-1)-th reference pulse, so code 6 gives one flag per 32 pulses. Codes 1 and 2 behave as codes 8 and 9. Code 0 never sets the flag.
- R8: The summary bit (flag bit 7) is set, and `irq_n` is low, exactly when some flag is set together with its enable at the same bit position in the control register.
- R9: Reading the flag register returns its current value and clears all flags. An event in the same cycle as that read is not lost: it appears at the next read.
- R10: Writes to the flag register have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| upd_tick | input | 1 | One-cycle pulse on each one-second time update |
| cur_sec | input | 8 | Current seconds from the time counter |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| cur_day | input | 8 | Current day of month |
| cur_mon | input | 8 | Current month |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The hardest case to reach is an alarm field that equals the current value bit for bit yet must not match. This happens because the field breaks the BCD, binary or 12-hour rule. A correct time counter never produces such values, so the stimulus drives out-of-range values straight onto the current-time inputs. A vector table pairs such values with equal alarm bytes under each mode. A second hard case is an update event that lands in the very cycle of a clearing flag read. A directed test drives `upd_tick` and the flag read in the same cycle and then reads the flags again.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    typedef enum logic [2:0] {
        RA_SEC  = 3'd0,
        RA_MIN  = 3'd1,
        RA_HOUR = 3'd2,
        RA_DAY  = 3'd3,
        RA_MON  = 3'd4,
        RA_RATE = 3'd5,
        RA_CTRL = 3'd6,
        RA_FLAG = 3'd7
    } reg_addr_e;

    // control and flag bit positions (enable and flag share a position)
    localparam int BIT_PER  = 6;
    localparam int BIT_ALM  = 5;
    localparam int BIT_UPD  = 4;
    localparam int BIT_BIN  = 2;
    localparam int BIT_H24  = 1;
    localparam int BIT_SUM  = 7;

    localparam logic [7:0] CTRL_RESET = 8'h02;

    // flags[2] periodic, flags[1] alarm, flags[0] update
    typedef struct packed {
        logic [7:0] alm_sec;
        logic [7:0] alm_min;
        logic [7:0] alm_hour;
        logic [7:0] alm_day;
        logic [7:0] alm_mon;
        logic [3:0] rate;
        logic [7:0] ctrl;
        logic [2:0] flags;
        logic [7:0] rd_data;
    } regs_t;

    function automatic logic is_wild(input logic [7:0] v);
        return v[7:6] == 2'b11;
    endfunction

    function automatic logic in_range(input logic [7:0] v, input logic [7:0] lim_bcd,
                                      input logic [7:0] lim_bin, input logic bin);
        if (bin)
            return v <= lim_bin;
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= lim_bcd);
    endfunction

    function automatic logic hour_ok(input logic [7:0] v, input logic bin, input logic h24);
        logic [7:0] h;
        h = {1'b0, v[6:0]};
        if (h24)
            return in_range(v, 8'h23, 8'd23, bin);
        return (h != 8'd0) && in_range(h, 8'h12, 8'd12, bin);
    endfunction

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY = 1'b1,
    parameter bit HAS_MON = 1'b1
) (
    input  logic       tick,
    input  logic       bin,
    input  logic       h24,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_day,
    input  logic [7:0] alm_mon,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_mon,
    output logic       hit
);

    logic sec_ok, min_ok, hour_match, day_ok, mon_ok;

    always_comb begin
        sec_ok = is_wild(alm_sec) ||
                 (in_range(alm_sec, 8'h59, 8'd59, bin) && alm_sec == cur_sec);
        min_ok = is_wild(alm_min) ||
                 (in_range(alm_min, 8'h59, 8'd59, bin) && alm_min == cur_min);
        hour_match = is_wild(alm_hour) ||
                 (hour_ok(alm_hour, bin, h24) && alm_hour == cur_hour);
    end

    generate
        if (HAS_DAY) begin : g_day
            logic [7:0] day6;
            always_comb begin
                day6   = {2'b00, alm_day[5:0]};
                day_ok = is_wild(alm_day) || (day6 == 8'd0) ||
                         (in_range(day6, 8'h31, 8'd31, bin) && day6 == cur_day);
            end
        end else begin : g_no_day
            assign day_ok = 1'b1;
        end
        if (HAS_MON) begin : g_mon
            always_comb
                mon_ok = is_wild(alm_mon) ||
                         (in_range(alm_mon, 8'h12, 8'd12, bin) && alm_mon == cur_mon);
        end else begin : g_no_mon
            assign mon_ok = 1'b1;
        end
    endgenerate

    assign hit = tick && sec_ok && min_ok && hour_match && day_ok && mon_ok;

endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div #(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic [3:0] rate,
    input  logic       restart,
    output logic       evt
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] mask;
    logic [3:0]       eff;

    always_comb begin
        case (rate)
            4'd1:    eff = 4'd8;
            4'd2:    eff = 4'd9;
            default: eff = rate;
        endcase
        mask  = (DIV_W'(1) << (eff - 4'd1)) - DIV_W'(1);
        evt   = ref_tick && (rate != 4'd0) && ((cnt_q & mask) == mask);
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (ref_tick)
            cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY = 1'b1,
    parameter bit HAS_MON = 1'b1,
    parameter int DIV_W   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       upd_tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_mon,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq_n
);

    regs_t q, d;

    logic       per_evt;
    logic       alarm_hit;
    logic       rate_restart;
    logic [2:0] enables;
    logic       summary;
    logic [2:0] flag_bits;
    logic [3:0] rate_bits;

    assign rate_restart = wr_en && (reg_addr_e'(addr) == RA_RATE);
    assign enables      = {q.ctrl[BIT_PER], q.ctrl[BIT_ALM], q.ctrl[BIT_UPD]};
    assign summary      = |(q.flags & enables);
    assign flag_bits    = q.flags;
    assign rate_bits    = q.rate;

    rtc_periodic_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .rate    (q.rate),
        .restart (rate_restart),
        .evt     (per_evt)
    );

    rtc_alarm_match #(.HAS_DAY(HAS_DAY), .HAS_MON(HAS_MON)) u_match (
        .tick    (upd_tick),
        .bin     (q.ctrl[BIT_BIN]),
        .h24     (q.ctrl[BIT_H24]),
        .alm_sec (q.alm_sec),
        .alm_min (q.alm_min),
        .alm_hour(q.alm_hour),
        .alm_day (q.alm_day),
        .alm_mon (q.alm_mon),
        .cur_sec (cur_sec),
        .cur_min (cur_min),
        .cur_hour(cur_hour),
        .cur_day (cur_day),
        .cur_mon (cur_mon),
        .hit     (alarm_hit)
    );

    always_comb begin
        d = q;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_SEC:  d.alm_sec  = wr_data;
                RA_MIN:  d.alm_min  = wr_data;
                RA_HOUR: d.alm_hour = wr_data;
                RA_DAY:  d.alm_day  = wr_data;
                RA_MON:  d.alm_mon  = wr_data;
                RA_RATE: d.rate     = wr_data[3:0];
                RA_CTRL: d.ctrl     = wr_data;
                default: ;
            endcase
        end
        if (rd_en) begin
            case (reg_addr_e'(addr))
                RA_SEC:  d.rd_data = q.alm_sec;
                RA_MIN:  d.rd_data = q.alm_min;
                RA_HOUR: d.rd_data = q.alm_hour;
                RA_DAY:  d.rd_data = q.alm_day;
                RA_MON:  d.rd_data = q.alm_mon;
                RA_RATE: d.rd_data = {4'h0, q.rate};
                RA_CTRL: d.rd_data = q.ctrl;
                default: begin
                    d.rd_data = {summary, q.flags, 4'h0};
                    d.flags   = 3'b000;
                end
            endcase
        end
        // events win over a clearing read in the same cycle
        if (per_evt)   d.flags[2] = 1'b1;
        if (alarm_hit) d.flags[1] = 1'b1;
        if (upd_tick)  d.flags[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rd_data;
    assign irq_n   = ~summary;

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic       upd_tick,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic       irq_n,
    input logic [2:0] flag_bits,
    input logic [3:0] rate_bits,
    input logic       per_evt,
    input logic       alarm_hit
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (flag_bits == 3'b000) && irq_n);

    // R3
    upd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_tick |=> flag_bits[0]);

    // R4
    alarm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_tick);

    // R7
    per_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_bits == 4'd0) |-> !per_evt);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag_bits != 3'b000));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd7 && !upd_tick && !ref_tick) |=> (flag_bits == 3'b000));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && addr == 3'd7) && !upd_tick && !ref_tick) |=> $stable(flag_bits));

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .upd_tick (upd_tick),
    .rd_en    (rd_en),
    .addr     (addr),
    .irq_n    (irq_n),
    .flag_bits(flag_bits),
    .rate_bits(rate_bits),
    .per_evt  (per_evt),
    .alarm_hit(alarm_hit)
);

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0, upd_tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0, cur_mon = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rtc_alarm_irq uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .upd_tick(upd_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_mon(cur_mon),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    typedef struct packed {
        logic       bin;
        logic [7:0] as_, am, ah, ad, ao;
        logic [7:0] cs, cm, ch, cd, co;
        logic       hit;
    } vec_t;

    // alarm match vectors, 24-hour mode, all enables off
    localparam vec_t VEC [12] = '{
        '{1'b0, 8'h30, 8'h15, 8'h12, 8'h10, 8'h06, 8'h30, 8'h15, 8'h12, 8'h10, 8'h06, 1'b1},
        '{1'b0, 8'h30, 8'h15, 8'h12, 8'h10, 8'h06, 8'h31, 8'h15, 8'h12, 8'h10, 8'h06, 1'b0},
        '{1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h07, 8'h44, 8'h19, 8'h28, 8'h11, 1'b1},
        '{1'b0, 8'hC5, 8'h15, 8'h12, 8'h10, 8'h06, 8'h07, 8'h15, 8'h12, 8'h10, 8'h06, 1'b1},
        '{1'b0, 8'h30, 8'h15, 8'h12, 8'h00, 8'h06, 8'h30, 8'h15, 8'h12, 8'h22, 8'h06, 1'b1},
        '{1'b0, 8'h30, 8'h15, 8'h12, 8'h50, 8'h06, 8'h30, 8'h15, 8'h12, 8'h10, 8'h06, 1'b1},
        '{1'b1, 8'h45, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h45, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0},
        '{1'b0, 8'h3C, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h3C, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0},
        '{1'b1, 8'h2D, 8'h0A, 8'h17, 8'h1F, 8'h0C, 8'h2D, 8'h0A, 8'h17, 8'h1F, 8'h0C, 1'b1},
        '{1'b1, 8'h2D, 8'h0A, 8'h17, 8'h1F, 8'h0B, 8'h2D, 8'h0A, 8'h17, 8'h1F, 8'h0C, 1'b0},
        '{1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h13, 8'h00, 8'h00, 8'h00, 8'h01, 8'h13, 1'b0},
        '{1'b0, 8'hFF, 8'hFF, 8'h23, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h22, 8'h01, 8'h01, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic upd();
        @(negedge clk);
        upd_tick = 1'b1;
        @(negedge clk);
        upd_tick = 1'b0;
    endtask

    task automatic refs(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    task automatic set_cur(input logic [7:0] s, m, h, dd, mo);
        cur_sec = s; cur_min = m; cur_hour = h; cur_day = dd; cur_mon = mo;
    endtask

    task automatic set_alm(input logic [7:0] s, m, h, dd, mo);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dd); wr(3'd4, mo);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset reg", v, (a == 6) ? 8'h02 : 8'h00);
        end

        // R2 readback
        wr(3'd0, 8'hA5); rd(3'd0, v); check("R2 sec alarm", v, 8'hA5);
        wr(3'd5, 8'hF6); rd(3'd5, v); check("R2 rate masked", v, 8'h06);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h06); rd(3'd6, v); check("R2 ctrl", v, 8'h06);

        // R10 writes to the flag register do nothing
        wr(3'd7, 8'hF0); rd(3'd7, v); check("R10 flag write ignored", v, 8'h00);

        // R4 R5 R3 vector table
        for (int i = 0; i < 12; i++) begin
            wr(3'd6, VEC[i].bin ? 8'h06 : 8'h02);
            set_alm(VEC[i].as_, VEC[i].am, VEC[i].ah, VEC[i].ad, VEC[i].ao);
            set_cur(VEC[i].cs, VEC[i].cm, VEC[i].ch, VEC[i].cd, VEC[i].co);
            rd(3'd7, v);
            upd();
            rd(3'd7, v);
            check("R4 R5 alarm flag", {7'd0, v[5]}, {7'd0, VEC[i].hit});
            check("R3 update flag", {7'd0, v[4]}, 8'h01);
        end

        // R6 12-hour rule
        wr(3'd6, 8'h00);
        set_alm(8'hFF, 8'hFF, 8'h81, 8'hFF, 8'hFF);
        set_cur(8'h00, 8'h00, 8'h81, 8'h01, 8'h01);
        rd(3'd7, v); upd(); rd(3'd7, v);
        check("R6 12h PM hour", v, 8'h30);
        wr(3'd2, 8'h13); cur_hour = 8'h13;
        upd(); rd(3'd7, v);
        check("R6 12h hour 13 rejected", v, 8'h10);
        wr(3'd2, 8'h00); cur_hour = 8'h00;
        upd(); rd(3'd7, v);
        check("R6 12h hour 0 rejected", v, 8'h10);

        // R8 summary and irq_n
        wr(3'd6, 8'h22);
        set_alm(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        upd();
        check("R8 irq_n low", {7'd0, irq_n}, 8'h00);
        rd(3'd7, v);
        check("R8 summary read", v, 8'hB0);
        check("R8 irq_n released", {7'd0, irq_n}, 8'h01);
        wr(3'd0, 8'h00); cur_sec = 8'h01;
        upd();
        check("R8 disabled flag no irq", {7'd0, irq_n}, 8'h01);
        rd(3'd7, v);
        check("R8 update only", v, 8'h10);

        // R9 event in the same cycle as the clearing read
        @(negedge clk);
        rd_en = 1'b1; addr = 3'd7; upd_tick = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; upd_tick = 1'b0;
        check("R9 read before event", rd_data, 8'h00);
        rd(3'd7, v);
        check("R9 event kept", v, 8'h10);
        rd(3'd7, v);
        check("R9 cleared", v, 8'h00);

        // R7 periodic divider
        wr(3'd6, 8'h42);
        wr(3'd5, 8'h06);
        refs(31); rd(3'd7, v);
        check("R7 rate 6 before 32", v, 8'h00);
        refs(1);
        check("R7 R8 periodic irq", {7'd0, irq_n}, 8'h00);
        rd(3'd7, v);
        check("R7 rate 6 at 32", v, 8'hC0);
        refs(32); rd(3'd7, v);
        check("R7 rate 6 second period", v, 8'hC0);
        wr(3'd5, 8'h03);
        refs(3); rd(3'd7, v); check("R7 rate 3 before 4", v, 8'h00);
        refs(1); rd(3'd7, v); check("R7 rate 3 at 4", v, 8'hC0);
        wr(3'd5, 8'h01);
        refs(127); rd(3'd7, v); check("R7 rate 1 before 128", v, 8'h00);
        refs(1); rd(3'd7, v); check("R7 rate 1 at 128", v, 8'hC0);
        wr(3'd5, 8'h00);
        refs(300); rd(3'd7, v); check("R7 rate 0 off", v, 8'h00);

        finish_run();
    end

endmodule